// File: doc/BRIEF.md
# Configurable UART transmit framer

This block turns a byte into an asynchronous serial character. A host writes the byte into a one-entry holding register. When the shift logic is idle, the byte moves into it. The block then sends a low start bit, the data bits least significant first, an optional parity bit, and one or more high stop bits. A separate divider supplies a one-cycle baud tick, and every serial bit lasts sixteen of those ticks. Because timing is counted in ticks, a stop interval of one and a half bits is possible.

The character format comes from line-control inputs: data length, stop-bit count, parity enable, parity sense, stick parity and break. The format is captured when a byte enters the shift logic, so a frame keeps one format from start to finish. The break input only forces the serial line low. The sequencing and the two status flags run exactly as they would without a break. A holding-empty flag tells the host when the next byte may be written. A transmitter-empty flag tells it when the line has gone fully quiet.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, the serial output is high (idle) and both the holding-empty and transmitter-empty flags are 1. While the transmitter is empty and break is 0, the line stays high.
- R2: The word-length code `wlen_i` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Each frame starts with one low start bit, followed by the data bits least significant first. Every bit lasts 16 baud ticks.
- R3: When parity is enabled and stick parity is 0, one parity bit follows the last data bit. It makes the count of ones over the data bits and the parity bit even when `par_even_i` is 1, and odd when it is 0.
- R4: When parity is enabled and stick parity is 1, the parity bit equals the inverse of `par_even_i`, whatever the data.
- R5: When parity is disabled, no parity bit is sent, and the stop bits follow the last data bit directly.
- R6: With `stop2_i` at 0 the stop interval is 16 ticks. With it at 1 the interval is 32 ticks, or 24 ticks when the word length is 5 bits.
- R7: While `brk_i` is 1, the serial output is 0. Frame timing and both flags are the same as without a break.
- R8: A write clears the holding-empty flag on the next clock. The flag sets again one clock later if the shift logic is idle, when the byte moves into the shift logic. A clear of the holding-empty flag is always caused by a write.
- R9: The transmitter-empty flag is 1 only when the holding register is empty and the shift logic is idle. It rises on the clock edge of the last baud tick of the stop interval.
- R10: A byte written during a frame is held until that frame's stop interval ends, and is then sent as the next frame without losing any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse per 1/16 bit time |
| wlen_i | input | 2 | Word length code (5 to 8 data bits) |
| stop2_i | input | 1 | Long stop interval select |
| par_en_i | input | 1 | Parity enable |
| par_even_i | input | 1 | Parity sense: 1 even, 0 odd |
| par_stick_i | input | 1 | Stick parity |
| brk_i | input | 1 | Force serial line low |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial output |
| hold_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and shift logic both idle |

## Verification
The hardest case to reach is the hand-off between frames. The second byte must wait in the holding register and enter the shift logic on the clock right after the last stop tick, with no tick lost or duplicated. The bench reaches this case by writing a second byte on the idle cycle just after the first byte is taken. It then tracks both frames tick by tick. The bench also sweeps every word length, both stop settings and all five parity modes on two data patterns. Break is checked by repeating a full frame with the line forced low and comparing the flag timing.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } lcr_t;

  function automatic logic [3:0] data_len(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  function automatic logic calc_parity(input lcr_t c, input logic [DATA_W-1:0] d);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(data_len(c.wlen))) acc = acc ^ d[i];
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? acc : ~acc;
  endfunction
endpackage

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  logic [DW-1:0] data_q;
  logic          full_q;

  // a write wins over a same-cycle take
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wdata_i;
      if (wr_i)        full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/utx_tick_timer.sv
module utx_tick_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= len_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign done_o = tick_i && (cnt_q == ONE);
endmodule

// File: rtl/utx_sequencer.sv
module utx_sequencer
  import utx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  lcr_t              lcr_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_len_o,
  output logic              take_o,
  output logic              line_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] BIT_LEN  = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] HALF_LEN = CNT_W'(OVS + OVS / 2);
  localparam logic [CNT_W-1:0] TWO_LEN  = CNT_W'(2 * OVS);

  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [3:0]        left_q, left_d;
  lcr_t              lcr_q;
  logic              par_q;
  logic [CNT_W-1:0]  stop_len;

  assign take_o = (phase_q == PH_IDLE) && hold_full_i;
  assign busy_o = (phase_q != PH_IDLE);

  always_comb begin
    if (!lcr_q.stop2)            stop_len = BIT_LEN;
    else if (lcr_q.wlen == 2'd0) stop_len = HALF_LEN;
    else                         stop_len = TWO_LEN;
  end

  always_comb begin
    phase_d    = phase_q;
    shreg_d    = shreg_q;
    left_d     = left_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = BIT_LEN;
    if (take_o) begin
      phase_d    = PH_START;
      shreg_d    = hold_data_i;
      tmr_load_o = 1'b1;
    end else if (tmr_done_i) begin
      unique case (phase_q)
        PH_START: begin
          phase_d    = PH_DATA;
          left_d     = data_len(lcr_q.wlen);
          tmr_load_o = 1'b1;
        end
        PH_DATA: begin
          shreg_d    = shreg_q >> 1;
          left_d     = left_q - 4'd1;
          tmr_load_o = 1'b1;
          if (left_q == 4'd1) begin
            phase_d   = lcr_q.par_en ? PH_PARITY : PH_STOP;
            tmr_len_o = lcr_q.par_en ? BIT_LEN : stop_len;
          end
        end
        PH_PARITY: begin
          phase_d    = PH_STOP;
          tmr_load_o = 1'b1;
          tmr_len_o  = stop_len;
        end
        PH_STOP: phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      lcr_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      shreg_q <= shreg_d;
      left_q  <= left_d;
      if (take_o) begin
        lcr_q <= lcr_i;
        par_q <= calc_parity(lcr_i, hold_data_i);
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START:  line_o = 1'b0;
      PH_DATA:   line_o = shreg_q[0];
      PH_PARITY: line_o = par_q;
      default:   line_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import utx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic [1:0] wlen_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic       brk_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       txd_o,
  output logic       hold_empty_o,
  output logic       tx_empty_o
);
  localparam int unsigned CNT_W = $clog2(2 * OVS + 1);

  logic              hold_full, take, line, busy;
  logic [DATA_W-1:0] hold_data;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_len;
  lcr_t              lcr;

  assign lcr = '{wlen: wlen_i, stop2: stop2_i, par_en: par_en_i,
                 par_even: par_even_i, par_stick: par_stick_i};

  utx_hold_reg #(.DW(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .take_i (take),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  utx_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(baud_tick_i),
    .load_i(tmr_load),
    .len_i (tmr_len),
    .done_o(tmr_done)
  );

  utx_sequencer #(.OVS(OVS), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_full_i(hold_full),
    .hold_data_i(hold_data),
    .lcr_i      (lcr),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .take_o     (take),
    .line_o     (line),
    .busy_o     (busy)
  );

  // break acts on the pin only
  assign txd_o        = brk_i ? 1'b0 : line;
  assign hold_empty_o = ~hold_full;
  assign tx_empty_o   = ~hold_full & ~busy;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic brk_i,
  input logic txd_o,
  input logic hold_empty_o,
  input logic tx_empty_o
);
  assert_break_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk_i) |-> txd_o);

  assert_write_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !hold_empty_o);

  assert_clear_needs_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_empty_o) |-> $past(wr_i));

  assert_empty_implies_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o);
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .brk_i       (brk_i),
  .txd_o       (txd_o),
  .hold_empty_o(hold_empty_o),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic       stop2 = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic       brk = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, hold_empty, tx_empty;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  uart_tx_framer #(.OVS(OVS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .baud_tick_i(tick),
    .wlen_i(wlen), .stop2_i(stop2), .par_en_i(par_en),
    .par_even_i(par_even), .par_stick_i(par_stick), .brk_i(brk),
    .wr_i(wr), .wdata_i(wdata), .txd_o(txd),
    .hold_empty_o(hold_empty), .tx_empty_o(tx_empty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d, expected under 190000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input int wl, input bit pe, input bit s2);
    int stop_t;
    stop_t = !s2 ? OVS : (wl == 5 ? OVS + OVS / 2 : 2 * OVS);
    return OVS * (1 + wl + (pe ? 1 : 0)) + stop_t;
  endfunction

  function automatic bit exp_par(input logic [7:0] d, input int wl,
                                 input bit ev, input bit st);
    bit acc;
    acc = 1'b0;
    for (int i = 0; i < wl; i++) acc ^= d[i];
    if (st) return !ev;
    return ev ? acc : !acc;
  endfunction

  function automatic bit exp_line(input int n, input int wl, input bit pe,
                                  input bit pb, input logic [7:0] d);
    int idx;
    idx = n / OVS;
    if (idx == 0) return 1'b0;
    if (idx <= wl) return d[idx-1];
    if (pe && idx == wl + 1) return pb;
    return 1'b1;
  endfunction

  // entered at the negedge right after the byte was taken; tick count n = 0
  task automatic run_frame(input string req, input logic [7:0] d,
                           input bit more, input bit brk_on);
    int wl, len, n, errs, first_n, first_a, first_e;
    bit pb;
    wl = 5 + int'(wlen);
    len = frame_len(wl, par_en, stop2);
    pb = exp_par(d, wl, par_even, par_stick);
    n = 0; errs = 0; first_n = -1; first_a = 0; first_e = 0;
    while (1) begin
      int ea, aa;
      bit lb;
      lb = (n < len) ? exp_line(n, wl, par_en, pb, d) : 1'b1;
      if (brk_on) lb = 1'b0;
      ea = {30'd0, (n >= len && !more), lb};
      aa = {30'd0, tx_empty, txd};
      if (aa != ea) begin
        errs++;
        if (first_n < 0) begin first_n = n; first_a = aa; first_e = ea; end
      end
      if (n >= len) break;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      n++;
      if (n < len) @(negedge clk);
    end
    checks++;
    if (errs != 0) begin
      fails++;
      $display("FAIL %s data %02h wlen %0d: tick %0d {tx_empty,txd} actual %0d expected %0d",
               req, d, wlen, first_n, first_a, first_e);
    end
  endtask

  task automatic send(input string req, input logic [7:0] d, input bit brk_on);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
    check("R8 write clears hold_empty", int'(hold_empty), 0);
    check("R9 tx_empty low with byte held", int'(tx_empty), 0);
    @(negedge clk);
    check("R8 hold_empty sets on transfer", int'(hold_empty), 1);
    run_frame(req, d, 1'b0, brk_on);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset txd", int'(txd), 1);
    check("R1 reset hold_empty", int'(hold_empty), 1);
    check("R1 reset tx_empty", int'(tx_empty), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle txd", int'(txd), 1);

    // sweep: all word lengths, stop settings, parity modes (R2 R3 R4 R5 R6)
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 2; s++)
        for (int pm = 0; pm < 5; pm++)
          for (int k = 0; k < 2; k++) begin
            string tag;
            wlen = 2'(w); stop2 = s[0];
            par_en = (pm != 0); par_even = (pm == 2 || pm == 4);
            par_stick = (pm >= 3);
            tag = (pm == 0) ? "R2 R5 R6" : (pm < 3 ? "R2 R3 R6" : "R2 R4 R6");
            send(tag, k == 0 ? 8'hB4 : 8'h5B, 1'b0);
          end

    // break during a full frame, same timing (R7)
    wlen = 2'd3; stop2 = 1'b1; par_en = 1'b1; par_even = 1'b0; par_stick = 1'b0;
    brk = 1'b1;
    send("R7 break frame", 8'hFF, 1'b1);
    check("R7 break on idle line", int'(txd), 0);
    brk = 1'b0;
    @(negedge clk);
    check("R7 line restored", int'(txd), 1);

    // back-to-back: second byte held until stop ends (R10)
    wlen = 2'd1; stop2 = 1'b0; par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0;
    @(negedge clk); wr = 1'b1; wdata = 8'h2D;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    check("R8 first byte taken", int'(hold_empty), 1);
    wr = 1'b1; wdata = 8'h13;
    @(negedge clk); wr = 1'b0;
    check("R10 second byte held", int'(hold_empty), 0);
    run_frame("R10 first frame", 8'h2D, 1'b1, 1'b0);
    check("R10 hold full at stop end", int'(hold_empty), 0);
    @(negedge clk);
    check("R10 second byte taken", int'(hold_empty), 1);
    run_frame("R10 second frame", 8'h13, 1'b0, 1'b0);
    check("R9 empty after last frame", int'(tx_empty), 1);

    summary();
  end
endmodule